// File: doc/BRIEF.md
# Colour Lookup Table with Sequenced Register Access

This block holds the colour table of a display pipeline. Software programs it through a 32-bit register port: it loads an 8-bit entry index, then sends the red, green and blue bytes of that entry one after another, each in the top byte of a data word. Once blue is written, the index steps to the next entry, so a whole table can be streamed after a single index load. A second data offset sends the same byte stream to a small overlay table used by a cursor stage. That table has four entries, selected by the two low bits of the index. Reads follow the same red, green, blue walk over the main table.

On the pixel side, an 8-bit pixel value goes in and the 24-bit colour of that main entry comes out one clock later. A 2-bit overlay selector returns an overlay colour with the same latency.

The sequencer is a three-state machine over the colour component: `PH_RED`, `PH_GRN` and `PH_BLU`. Every accepted component access (a main write, an overlay write or a read) moves `PH_RED` to `PH_GRN`, `PH_GRN` to `PH_BLU`, and `PH_BLU` back to `PH_RED`. The move out of `PH_BLU` also increments the index. An index load forces the machine from any state to `PH_RED`. All other cycles hold the state.

Top module: `clut_regif`

## Requirements
- R1: A full-word write at byte offset 0 loads the index from data bits 31:24 and puts the sequencer in `PH_RED`.
- R2: Full-word writes at byte offset 4 store data bits 31:24 into the red, then green, then blue byte of the main entry at the current index, advancing one state per write.
- R3: The access that handles blue increments the index modulo 256 and returns the sequencer to `PH_RED`, so entry 255 is followed by entry 0.
- R4: Full-word writes at byte offset 12 store into overlay slot (index mod 4) with the same state sequence and index increment. They leave the main table unchanged, and they share the one sequencer with main writes and reads.
- R5: A full-word read returns the current main entry's red, green, then blue byte in bits 31:24 with bits 23:0 zero. The value appears on `bus_rdata` in the cycle after the read strobe. Reads advance the same sequencer as writes.
- R6: After reset, every main entry is zero except entry 255, which is FFFFFF. Overlay slots 0 and 2 are FFFFFF and slots 1 and 3 are zero. The index is 0, the state is `PH_RED` and `bus_rdata` is zero.
- R7: An access whose byte enables are not all set, a write to any offset other than 0, 4 or 12, and a read strobe in the same cycle as a write strobe each change neither the tables, the index, the state nor `bus_rdata`.
- R8: `pix_rgb` shows the main entry addressed by `pix_idx` one clock later, packed as red in 23:16, green in 15:8 and blue in 7:0.
- R9: `ovl_rgb` shows the overlay slot addressed by `ovl_sel` one clock later, with the same packing.
- R10: When a main write and a pixel lookup hit the same entry in one cycle, the lookup returns the entry's value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Byte offset of the access |
| bus_be | input | 4 | Byte enables; an access is accepted only when all four are set |
| bus_wdata | input | 32 | Write data; index or colour byte in bits 31:24 |
| bus_rdata | output | 32 | Read data, registered, component in bits 31:24 |
| pix_idx | input | 8 | Pixel value to look up in the main table |
| pix_rgb | output | 24 | Colour of the looked-up main entry |
| ovl_sel | input | 2 | Overlay slot to look up |
| ovl_rgb | output | 24 | Colour of the selected overlay slot |

## Verification
The main table is programmed in several ways: a plain three-byte stream after an index load, a stream that crosses entry 255 into entry 0, and a stream written with no index load after reset. Together these separate a correct increment and wrap from an index that sticks or fails to reset. Overlay streams aimed at index values 6 and 7 show that the slot is taken from the low index bits while the main entries at those indices stay untouched. A stream that interleaves main and overlay writes shows that the two share one state machine rather than keeping separate counters. Read streams, reads mixed with writes, partial-enable and wrong-offset accesses, and a lookup that coincides with a blue write show the shared read sequencing, the rejection rules and the return of the old value on a collision.

// File: rtl/clut_pkg.sv
package clut_pkg;

    localparam int CLR_W = 8;
    localparam int RGB_W = 3 * CLR_W;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    // Replace one colour byte of a packed {r,g,b} word.
    function automatic logic [RGB_W-1:0] put_comp(
        input logic [RGB_W-1:0] old_rgb,
        input phase_e           ph,
        input logic [CLR_W-1:0] val
    );
        logic [RGB_W-1:0] res;
        res = old_rgb;
        unique case (ph)
            PH_RED:  res[RGB_W-1   -: CLR_W] = val;
            PH_GRN:  res[2*CLR_W-1 -: CLR_W] = val;
            default: res[CLR_W-1   -: CLR_W] = val;
        endcase
        return res;
    endfunction

    // Extract one colour byte of a packed {r,g,b} word.
    function automatic logic [CLR_W-1:0] get_comp(
        input logic [RGB_W-1:0] rgb,
        input phase_e           ph
    );
        logic [CLR_W-1:0] res;
        unique case (ph)
            PH_RED:  res = rgb[RGB_W-1   -: CLR_W];
            PH_GRN:  res = rgb[2*CLR_W-1 -: CLR_W];
            default: res = rgb[CLR_W-1   -: CLR_W];
        endcase
        return res;
    endfunction

endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int IDX_W     = 8,
    parameter int OVL_N     = 4,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int OFS_INDEX = 0,
    parameter int OFS_MAIN  = 4,
    parameter int OFS_OVL   = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W/8-1:0]       bus_be,
    input  logic [DATA_W-1:0]         bus_wdata,
    input  logic [RGB_W-1:0]          idx_rgb,
    output logic                      main_we,
    output logic                      ovl_we,
    output logic [IDX_W-1:0]          wr_index,
    output logic [$clog2(OVL_N)-1:0]  wr_slot,
    output phase_e                    wr_phase,
    output logic [CLR_W-1:0]          wr_byte,
    output logic [DATA_W-1:0]         bus_rdata
);
    localparam int OVL_W   = $clog2(OVL_N);
    localparam int TOP_LSB = DATA_W - CLR_W;

    phase_e            phase_q, phase_d;
    logic [IDX_W-1:0]  index_q, index_d;
    logic              full_word, hit_idx, hit_main, hit_ovl, rd_ok, step;
    logic              unused_low;

    assign unused_low = ^bus_wdata[TOP_LSB-1:0];

    // Access decode
    always_comb begin
        full_word = &bus_be;
        hit_idx   = bus_wr && full_word && (bus_addr == ADDR_W'(OFS_INDEX));
        hit_main  = bus_wr && full_word && (bus_addr == ADDR_W'(OFS_MAIN));
        hit_ovl   = bus_wr && full_word && (bus_addr == ADDR_W'(OFS_OVL));
        rd_ok     = bus_rd && !bus_wr && full_word;
        step      = hit_main || hit_ovl || rd_ok;
    end

    // Next-state logic
    always_comb begin
        phase_d = phase_q;
        index_d = index_q;
        if (hit_idx) begin
            phase_d = PH_RED;
            index_d = bus_wdata[DATA_W-1 -: IDX_W];
        end else if (step) begin
            unique case (phase_q)
                PH_RED: phase_d = PH_GRN;
                PH_GRN: phase_d = PH_BLU;
                PH_BLU: begin
                    phase_d = PH_RED;
                    index_d = index_q + 1'b1;
                end
                default: phase_d = PH_RED;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_RED;
            index_q <= '0;
        end else begin
            phase_q <= phase_d;
            index_q <= index_d;
        end
    end

    // Read data register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_ok) begin
            bus_rdata <= {get_comp(idx_rgb, phase_q), {TOP_LSB{1'b0}}};
        end
    end

    // Outputs towards the table storage
    always_comb begin
        main_we  = hit_main;
        ovl_we   = hit_ovl;
        wr_index = index_q;
        wr_slot  = index_q[OVL_W-1:0];
        wr_phase = phase_q;
        wr_byte  = bus_wdata[DATA_W-1 -: CLR_W];
    end

    a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        hit_idx |=> (phase_q == PH_RED) && (index_q == $past(bus_wdata[DATA_W-1 -: IDX_W])));

    a_r2_red_to_green: assert property (@(posedge clk) disable iff (!rst_n)
        (step && phase_q == PH_RED) |=> (phase_q == PH_GRN) && $stable(index_q));

    a_r3_blue_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (step && phase_q == PH_BLU) |=> (phase_q == PH_RED) && (index_q == IDX_W'($past(index_q) + 1'b1)));

    a_r7_rejected_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit_idx && !hit_main && !hit_ovl) |=> $stable(index_q) && $stable(phase_q) && $stable(bus_rdata));

    always_comb begin
        if (rst_n) begin
            a_r5_low_zero: assert (bus_rdata[TOP_LSB-1:0] == '0);
        end
    end

endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int OVL_N = 4,
    parameter logic [OVL_N-1:0] OVL_WHITE = 4'b0101
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      main_we,
    input  logic                      ovl_we,
    input  logic [IDX_W-1:0]          wr_index,
    input  logic [$clog2(OVL_N)-1:0]  wr_slot,
    input  phase_e                    wr_phase,
    input  logic [CLR_W-1:0]          wr_byte,
    output logic [RGB_W-1:0]          idx_rgb,
    input  logic [IDX_W-1:0]          pix_idx,
    output logic [RGB_W-1:0]          pix_rgb,
    input  logic [$clog2(OVL_N)-1:0]  ovl_sel,
    output logic [RGB_W-1:0]          ovl_rgb
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam logic [RGB_W-1:0] WHITE = '1;

    logic [RGB_W-1:0] pal   [ENTRIES];
    logic [RGB_W-1:0] ovl_q [OVL_N];

    // Main table
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                pal[i] <= (i == ENTRIES - 1) ? WHITE : '0;
            end
        end else if (main_we) begin
            pal[wr_index] <= put_comp(pal[wr_index], wr_phase, wr_byte);
        end
    end

    // Overlay slots, each with its own reset colour
    for (genvar s = 0; s < OVL_N; s++) begin : g_ovl
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ovl_q[s] <= OVL_WHITE[s] ? WHITE : '0;
            end else if (ovl_we && (wr_slot == s)) begin
                ovl_q[s] <= put_comp(ovl_q[s], wr_phase, wr_byte);
            end
        end
    end

    assign idx_rgb = pal[wr_index];

    // Registered lookups
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_rgb <= '0;
            ovl_rgb <= '0;
        end else begin
            pix_rgb <= pal[pix_idx];
            ovl_rgb <= ovl_q[ovl_sel];
        end
    end

    a_r10_old_on_collide: assert property (@(posedge clk) disable iff (!rst_n)
        (main_we && wr_index == pix_idx) |=> (pix_rgb == $past(idx_rgb)));

    a_r4_overlay_spares_main: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_we && !main_we) |=> (idx_rgb == $past(idx_rgb)) || (wr_index != $past(wr_index)));

endmodule

// File: rtl/clut_regif.sv
module clut_regif
    import clut_pkg::*;
#(
    parameter int IDX_W     = 8,
    parameter int OVL_N     = 4,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int OFS_INDEX = 0,
    parameter int OFS_MAIN  = 4,
    parameter int OFS_OVL   = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W/8-1:0]       bus_be,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [IDX_W-1:0]          pix_idx,
    output logic [RGB_W-1:0]          pix_rgb,
    input  logic [$clog2(OVL_N)-1:0]  ovl_sel,
    output logic [RGB_W-1:0]          ovl_rgb
);
    localparam int OVL_W = $clog2(OVL_N);

    logic              main_we, ovl_we;
    logic [IDX_W-1:0]  wr_index;
    logic [OVL_W-1:0]  wr_slot;
    phase_e            wr_phase;
    logic [CLR_W-1:0]  wr_byte;
    logic [RGB_W-1:0]  idx_rgb;

    clut_seq #(
        .IDX_W(IDX_W), .OVL_N(OVL_N), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .OFS_INDEX(OFS_INDEX), .OFS_MAIN(OFS_MAIN), .OFS_OVL(OFS_OVL)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .idx_rgb   (idx_rgb),
        .main_we   (main_we),
        .ovl_we    (ovl_we),
        .wr_index  (wr_index),
        .wr_slot   (wr_slot),
        .wr_phase  (wr_phase),
        .wr_byte   (wr_byte),
        .bus_rdata (bus_rdata)
    );

    clut_store #(
        .IDX_W(IDX_W), .OVL_N(OVL_N)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .main_we  (main_we),
        .ovl_we   (ovl_we),
        .wr_index (wr_index),
        .wr_slot  (wr_slot),
        .wr_phase (wr_phase),
        .wr_byte  (wr_byte),
        .idx_rgb  (idx_rgb),
        .pix_idx  (pix_idx),
        .pix_rgb  (pix_rgb),
        .ovl_sel  (ovl_sel),
        .ovl_rgb  (ovl_rgb)
    );

    a_r6_reset_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bus_rdata == '0));

endmodule

// File: tb/tb_clut_regif.sv
`timescale 1ns/1ps
module tb_clut_regif;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;
    logic [1:0]  ovl_sel = '0;
    logic [23:0] ovl_rgb;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    clut_regif dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pix_idx(pix_idx), .pix_rgb(pix_rgb),
        .ovl_sel(ovl_sel), .ovl_rgb(ovl_rgb)
    );

    // Vector: {req[3:0], op[1:0], addr[3:0], data[31:0], exp[31:0]}
    // op 0 = full write, 1 = full read, 2 = pixel lookup, 3 = overlay lookup
    localparam int NV = 39;
    localparam logic [73:0] VEC [NV] = '{
        {4'd1, 2'd0, 4'h0, 32'h1000_0000, 32'h0},          // R1 index 0x10
        {4'd2, 2'd0, 4'h4, 32'hAA00_0000, 32'h0},          // R2 red
        {4'd2, 2'd0, 4'h4, 32'hBB00_0000, 32'h0},          // R2 green
        {4'd2, 2'd0, 4'h4, 32'hCC00_0000, 32'h0},          // R2 blue
        {4'd1, 2'd0, 4'h0, 32'h1000_0000, 32'h0},          // R1 reload
        {4'd5, 2'd1, 4'h0, 32'h0,         32'hAA00_0000},  // R5
        {4'd5, 2'd1, 4'h0, 32'h0,         32'hBB00_0000},  // R5
        {4'd5, 2'd1, 4'h0, 32'h0,         32'hCC00_0000},  // R5
        {4'd8, 2'd2, 4'h0, 32'h10,        32'h00AA_BBCC},  // R8
        {4'd8, 2'd2, 4'h0, 32'h11,        32'h0},          // R8
        {4'd1, 2'd0, 4'h0, 32'hFF00_0000, 32'h0},          // R1 index 255
        {4'd3, 2'd0, 4'h4, 32'h0100_0000, 32'h0},          // R3
        {4'd3, 2'd0, 4'h4, 32'h0200_0000, 32'h0},          // R3
        {4'd3, 2'd0, 4'h4, 32'h0300_0000, 32'h0},          // R3 wraps to 0
        {4'd3, 2'd0, 4'h4, 32'h4400_0000, 32'h0},          // R3
        {4'd3, 2'd0, 4'h4, 32'h5500_0000, 32'h0},          // R3
        {4'd3, 2'd0, 4'h4, 32'h6600_0000, 32'h0},          // R3
        {4'd3, 2'd2, 4'h0, 32'hFF,        32'h0001_0203},  // R3
        {4'd3, 2'd2, 4'h0, 32'h00,        32'h0044_5566},  // R3
        {4'd4, 2'd0, 4'h0, 32'h0600_0000, 32'h0},          // R4 index 6 -> slot 2
        {4'd4, 2'd0, 4'hC, 32'h1100_0000, 32'h0},          // R4
        {4'd4, 2'd0, 4'hC, 32'h2200_0000, 32'h0},          // R4
        {4'd4, 2'd0, 4'hC, 32'h3300_0000, 32'h0},          // R4 -> index 7
        {4'd4, 2'd0, 4'hC, 32'h7700_0000, 32'h0},          // R4 slot 3
        {4'd4, 2'd0, 4'hC, 32'h8800_0000, 32'h0},          // R4
        {4'd4, 2'd0, 4'hC, 32'h9900_0000, 32'h0},          // R4
        {4'd9, 2'd3, 4'h0, 32'h2,         32'h0011_2233},  // R9
        {4'd9, 2'd3, 4'h0, 32'h3,         32'h0077_8899},  // R9
        {4'd4, 2'd2, 4'h0, 32'h06,        32'h0},          // R4 main untouched
        {4'd4, 2'd0, 4'h0, 32'h2000_0000, 32'h0},          // R4 shared state
        {4'd4, 2'd0, 4'h4, 32'hA100_0000, 32'h0},          // R4 main red
        {4'd4, 2'd0, 4'hC, 32'hB200_0000, 32'h0},          // R4 overlay 0 green
        {4'd4, 2'd0, 4'h4, 32'hC300_0000, 32'h0},          // R4 main blue
        {4'd4, 2'd2, 4'h0, 32'h20,        32'h00A1_00C3},  // R4
        {4'd4, 2'd3, 4'h0, 32'h0,         32'h00FF_B2FF},  // R4
        {4'd1, 2'd0, 4'h0, 32'h2000_0000, 32'h0},          // R1
        {4'd5, 2'd1, 4'h0, 32'h0,         32'hA100_0000},  // R5
        {4'd5, 2'd1, 4'h0, 32'h0,         32'h0},          // R5
        {4'd5, 2'd1, 4'h0, 32'h0,         32'hC300_0000}   // R5
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic do_rd(input logic [3:0] be, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_be = be;
        @(negedge clk);
        bus_rd = 1'b0; bus_be = '0;
        v = bus_rdata;
    endtask

    task automatic look(input logic [7:0] i, output logic [23:0] v);
        @(negedge clk);
        pix_idx = i;
        @(negedge clk);
        v = pix_rgb;
    endtask

    task automatic look_ovl(input logic [1:0] s, output logic [23:0] v);
        @(negedge clk);
        ovl_sel = s;
        @(negedge clk);
        v = ovl_rgb;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r32;
        logic [31:0] held;
        logic [23:0] r24;
        apply_reset();

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [73:0] v;
            v = VEC[i];
            unique case (v[69:68])
                2'd0: do_wr(v[67:64], v[63:32], 4'hF);
                2'd1: begin
                    do_rd(4'hF, r32);
                    check($sformatf("R%0d vec%0d read", v[73:70], i), r32, v[31:0]);
                end
                2'd2: begin
                    look(v[39:32], r24);
                    check($sformatf("R%0d vec%0d pixel", v[73:70], i), {8'h0, r24}, v[31:0]);
                end
                default: begin
                    look_ovl(v[33:32], r24);
                    check($sformatf("R%0d vec%0d overlay", v[73:70], i), {8'h0, r24}, v[31:0]);
                end
            endcase
        end

        // R6: reset values
        apply_reset();
        @(negedge clk);
        check("R6 rdata after reset", bus_rdata, 32'h0);
        look(8'hFF, r24); check("R6 entry 255 white", {8'h0, r24}, 32'h00FF_FFFF);
        look(8'h00, r24); check("R6 entry 0 cleared", {8'h0, r24}, 32'h0);
        look(8'h10, r24); check("R6 entry 0x10 cleared", {8'h0, r24}, 32'h0);
        for (int s = 0; s < 4; s++) begin
            look_ovl(2'(s), r24);
            check($sformatf("R6 overlay slot %0d", s), {8'h0, r24},
                  (s % 2 == 0) ? 32'h00FF_FFFF : 32'h0);
        end
        // R6: index and state start at entry 0, red
        do_wr(4'h4, 32'h1200_0000, 4'hF);
        do_wr(4'h4, 32'h3400_0000, 4'hF);
        do_wr(4'h4, 32'h5600_0000, 4'hF);
        look(8'h00, r24); check("R6 index zero after reset", {8'h0, r24}, 32'h0012_3456);

        // R7: partial enables and stray offset are ignored
        do_wr(4'h0, 32'h3000_0000, 4'hF);
        do_wr(4'h4, 32'hEE00_0000, 4'h7);
        do_wr(4'h8, 32'hDD00_0000, 4'hF);
        do_wr(4'h0, 32'h5000_0000, 4'hE);
        do_wr(4'h4, 32'h0100_0000, 4'hF);
        do_wr(4'h4, 32'h0200_0000, 4'hF);
        do_wr(4'h4, 32'h0300_0000, 4'hF);
        look(8'h30, r24); check("R7 rejected writes", {8'h0, r24}, 32'h0001_0203);

        // R7: partial read leaves rdata and state alone
        do_wr(4'h0, 32'h3000_0000, 4'hF);
        do_rd(4'hF, r32); check("R5 red of 0x30", r32, 32'h0100_0000);
        do_rd(4'h3, r32); check("R7 partial read holds rdata", r32, 32'h0100_0000);
        do_rd(4'hF, r32); check("R7 partial read no advance", r32, 32'h0200_0000);

        // R5: read then write share the state
        do_wr(4'h0, 32'h4000_0000, 4'hF);
        do_rd(4'hF, r32); check("R5 red of 0x40", r32, 32'h0);
        do_wr(4'h4, 32'h5500_0000, 4'hF);
        look(8'h40, r24); check("R5 write lands in green", {8'h0, r24}, 32'h0000_5500);

        // R7: read strobe together with write is ignored
        do_wr(4'h0, 32'h6000_0000, 4'hF);
        do_rd(4'hF, r32);
        held = r32;
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h7700_0000; bus_be = 4'hF;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_be = '0;
        check("R7 read with write ignored", bus_rdata, held);
        look(8'h60, r24); check("R7 write with read lands in green", {8'h0, r24}, 32'h0000_7700);

        // R10: collision returns the old value, then the new one
        do_wr(4'h0, 32'h5000_0000, 4'hF);
        do_wr(4'h4, 32'h0A00_0000, 4'hF);
        do_wr(4'h4, 32'h0B00_0000, 4'hF);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h0C00_0000; bus_be = 4'hF;
        pix_idx = 8'h50;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
        check("R10 old value on collision", {8'h0, pix_rgb}, 32'h000A_0B00);
        @(negedge clk);
        check("R8 new value next cycle", {8'h0, pix_rgb}, 32'h000A_0B0C);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule